// File: doc/BRIEF.md
# Punch Decode Serializer

This block accepts one image byte from a wide external output bus in a single parallel load and then presents it, one bit at a time, on a single punch decode line. A scan sequencer issues the advance pulses that move it through the byte. The byte in storage holds the inverse of the holes to punch. A stored one therefore means "no hole": after the advance that consumes that bit, the decode line is low. A stored zero drives the line high.

A load takes place only when the gate strobe, the field-decode match and the mode enable are all high in the same cycle. The load clears the decode latch, so the line is inactive until the first advance, and it clears the end-of-byte flag. The sequencer can hold advances off with an inhibit input. When the eighth bit has reached the decode latch, the block raises its end-of-byte flag. Later advances then have no effect until the next load.

Top module: `punch_decode_ser`

## Requirements
- R1: After reset, `punch_decode` is 0 and `byte_done` is 1. Advances have no effect until the first load.
- R2: A load takes place only in a cycle in which `enter_pulse`, `field_hit` and `mode_on` are all 1. With any other combination, the outputs do not change.
- R3: In the cycle after a load, `punch_decode` is 0 and `byte_done` is 0.
- R4: Each accepted advance moves exactly one stored bit into the decode latch, starting with bus bit 0 and ending with bus bit 7. In the cycle after the advance, `punch_decode` equals the inverse of that bit.
- R5: An advance given while `adv_block` is 1 changes neither output.
- R6: `byte_done` becomes 1 in the cycle after the eighth accepted advance, with bit 7 shown on `punch_decode`. It stays 0 after the first seven.
- R7: When a load and an advance occur in the same cycle, the load is performed and the advance is dropped.
- R8: While `byte_done` is 1, advances leave `punch_decode` and `byte_done` unchanged.
- R9: A load in the middle of a byte discards the bits that remain and restarts with the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_bus | input | 8 | Image byte (inverted punch pattern) |
| enter_pulse | input | 1 | Gate strobe from the CPU side |
| field_hit | input | 1 | Field-decode match qualifier |
| mode_on | input | 1 | Mode enable qualifier |
| adv_pulse | input | 1 | Advance request, one bit per pulse |
| adv_block | input | 1 | Inhibits advances while 1 |
| punch_decode | output | 1 | Decode latch: 1 means punch this position |
| byte_done | output | 1 | All eight bits have been consumed |

## Verification
The hardest case to reach from the ports is the eighth advance landing at the boundary of a byte, followed at once by a load, an inhibited advance or an advance arriving after the end. To reach it, the stimulus sweeps all 256 byte values. Each byte is walked through its eight advances with an inhibited advance placed partway through, and one extra advance is given after the end. Loads that collide with an advance and loads with partial qualifiers are rotated across the sweep. A separate reload in the middle of a byte covers the restart case.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int unsigned PSD_BITS = 8;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } psd_act_e;
endpackage

// File: rtl/psd_gate.sv
module psd_gate
    import psd_pkg::*;
(
    input  logic     enter_pulse,
    input  logic     field_hit,
    input  logic     mode_on,
    input  logic     adv_pulse,
    input  logic     adv_block,
    input  logic     done,
    output psd_act_e act
);
    logic qual_load;

    always_comb begin
        qual_load = enter_pulse & field_hit & mode_on;
        if (qual_load)
            act = ACT_LOAD;
        else if (adv_pulse && !adv_block && !done)
            act = ACT_STEP;
        else
            act = ACT_IDLE;
    end
endmodule

// File: rtl/psd_shift.sv
module psd_shift
    import psd_pkg::*;
#(
    parameter int unsigned W = PSD_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  psd_act_e     act,
    input  logic [W-1:0] load_bits,
    output logic         latch_out
);
    typedef struct packed {
        logic [W-1:0] bits;
        logic         latch;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.bits  = load_bits;
                st_d.latch = 1'b0;
            end
            ACT_STEP: begin
                st_d.latch = ~st_q.bits[0];
                st_d.bits  = {1'b0, st_q.bits[W-1:1]};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign latch_out = st_q.latch;

    // R3
    load_clears_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LOAD) |=> !latch_out);

    // R5
    idle_holds_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_IDLE) |=> $stable(latch_out));
endmodule

// File: rtl/psd_tracker.sv
module psd_tracker
    import psd_pkg::*;
#(
    parameter int unsigned W = PSD_BITS
) (
    input  logic     clk,
    input  logic     rst_n,
    input  psd_act_e act,
    output logic     done
);
    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } trk_t;

    trk_t tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        unique case (act)
            ACT_LOAD: begin
                tk_d.cnt  = '0;
                tk_d.done = 1'b0;
            end
            ACT_STEP: begin
                tk_d.cnt  = tk_q.cnt + 1'b1;
                tk_d.done = (tk_q.cnt == LAST);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_q.cnt  <= '0;
            tk_q.done <= 1'b1;
        end else begin
            tk_q <= tk_d;
        end
    end

    assign done = tk_q.done;

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && act != ACT_LOAD) |=> done);

    // R6
    done_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(act) == ACT_STEP));
endmodule

// File: rtl/punch_decode_ser.sv
module punch_decode_ser
    import psd_pkg::*;
#(
    parameter int unsigned W = PSD_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_bus,
    input  logic         enter_pulse,
    input  logic         field_hit,
    input  logic         mode_on,
    input  logic         adv_pulse,
    input  logic         adv_block,
    output logic         punch_decode,
    output logic         byte_done
);
    psd_act_e act_w;

    psd_gate u_gate (
        .enter_pulse (enter_pulse),
        .field_hit   (field_hit),
        .mode_on     (mode_on),
        .adv_pulse   (adv_pulse),
        .adv_block   (adv_block),
        .done        (byte_done),
        .act         (act_w)
    );

    psd_shift #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act_w),
        .load_bits (ext_bus),
        .latch_out (punch_decode)
    );

    psd_tracker #(.W(W)) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act_w),
        .done  (byte_done)
    );

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_pulse && field_hit && mode_on && adv_pulse) |=> (!byte_done && !punch_decode));

    // R8
    done_freezes_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !(enter_pulse && field_hit && mode_on)) |=> $stable(punch_decode));
endmodule

// File: tb/sim_punch_decode_ser.sv
module sim_punch_decode_ser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ext_bus = '0;
    logic       enter_pulse = 1'b0, field_hit = 1'b0, mode_on = 1'b0;
    logic       adv_pulse = 1'b0, adv_block = 1'b0;
    logic       punch_decode, byte_done;

    int checks = 0;
    int errors = 0;
    logic exp_p, exp_d;

    always #2 clk = ~clk;

    punch_decode_ser u0 (
        .clk(clk), .rst_n(rst_n), .ext_bus(ext_bus),
        .enter_pulse(enter_pulse), .field_hit(field_hit), .mode_on(mode_on),
        .adv_pulse(adv_pulse), .adv_block(adv_block),
        .punch_decode(punch_decode), .byte_done(byte_done)
    );

    task automatic check(input string req);
        checks++;
        if (punch_decode !== exp_p || byte_done !== exp_d) begin
            errors++;
            $display("FAIL %s: punch=%b done=%b expected punch=%b done=%b",
                     req, punch_decode, byte_done, exp_p, exp_d);
        end
    endtask

    task automatic cycle(input logic [7:0] bus, input logic [2:0] q,
                         input logic adv, input logic blk);
        ext_bus = bus;
        {enter_pulse, field_hit, mode_on} = q;
        adv_pulse = adv;
        adv_block = blk;
        @(posedge clk);
        @(negedge clk);
        {enter_pulse, field_hit, mode_on} = 3'b000;
        adv_pulse = 1'b0;
        adv_block = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_p = 1'b0; exp_d = 1'b1;
        check("R1 reset");
        cycle(8'h00, 3'b000, 1'b1, 1'b0);
        check("R1 advance before load");

        for (int b = 0; b < 256; b++) begin
            logic [7:0] v = 8'(b);
            logic [2:0] partial = 3'(b % 7);
            // R2: partial qualifier, nothing changes
            cycle(~v, partial, 1'b1, 1'b0);
            check("R2 unqualified load");
            // R3 / R7: load, sometimes with a coincident advance
            cycle(v, 3'b111, (b % 4) == 0, 1'b0);
            exp_p = 1'b0; exp_d = 1'b0;
            check((b % 4) == 0 ? "R7 load over advance" : "R3 load");
            for (int k = 0; k < 8; k++) begin
                if (k == 3) begin
                    cycle(8'h00, 3'b000, 1'b1, 1'b1);
                    check("R5 blocked advance");
                end
                cycle(8'h00, 3'b000, 1'b1, 1'b0);
                exp_p = ~v[k];
                exp_d = (k == 7);
                check(k == 7 ? "R6 end of byte" : "R4 bit out");
            end
            cycle(8'h00, 3'b000, 1'b1, 1'b0);
            check("R8 advance after end");
        end

        // R9: reload in the middle of a byte
        cycle(8'hA5, 3'b111, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) cycle(8'h00, 3'b000, 1'b1, 1'b0);
        exp_p = ~1'b1; exp_d = 1'b0;
        check("R9 before reload");
        cycle(8'h0E, 3'b111, 1'b0, 1'b0);
        exp_p = 1'b0; exp_d = 1'b0;
        check("R9 reload");
        for (int k = 0; k < 8; k++) begin
            logic [7:0] nb = 8'h0E;
            cycle(8'h00, 3'b000, 1'b1, 1'b0);
            exp_p = ~nb[k]; exp_d = (k == 7);
            check("R9 restarted byte");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule